// File: doc/BRIEF.md
# Selectable Reference Divider with Phase/Frequency Detector

This block sits in a synthesizer loop and turns a 4 MHz oscillator clock into a slow comparison tick. It then compares that tick with a feedback pulse from the loop's main divider. A band bit and a step bit pick one of four divide ratios. The ratios are 320, 160, 4000 and 1600, which give comparison rates of 12.5 kHz, 25 kHz, 1 kHz and 2.5 kHz.

The tick drives a three-state phase/frequency detector. The detector raises a pump-up enable when the reference leads and a pump-down enable when the feedback leads. Each enable stays high for as many oscillator cycles as the phase error. A separate 2-bit current level is taken from two independent select bits, and the analog pump uses it to set its magnitude.

A low-power hold freezes the divider and silences the detector. Changing the ratio restarts the divider from zero, so the first tick at the new rate comes one full period after the change.

Top module: `refdiv_pfd`

## Requirements
- R1: While `rstN` is low, `refPulse`, `pumpUp` and `pumpDn` are 0, `pumpOff` is 1 and `pumpLevel` is 0.
- R2: The ratio select {`bandAm`,`stepWide`} sets the tick period in clock cycles: 00 gives 320, 01 gives 160, 10 gives 4000 and 11 gives 1600. The first tick after reset release, or after a ratio change, comes one full period after that event.
- R3: `refPulse` is high for exactly one clock cycle per period.
- R4: `pumpUp` rises in the cycle after `refPulse` is high.
- R5: `pumpDn` rises in the cycle after `fbPulse` is first seen high. A feedback pulse that stays high counts as one edge only.
- R6: When both enables are high, both are 0 in the next cycle. The leading enable stays high alone for exactly as many cycles as the lag, and both are high together for one cycle.
- R7: `pumpOff` is 1 exactly when neither `pumpUp` nor `pumpDn` is high.
- R8: While `standby` is high, the divider count holds, `refPulse`, `pumpUp` and `pumpDn` stay 0, and feedback edges are ignored. The count resumes from where it stopped.
- R9: A change of the ratio select clears both enables in the next cycle and restarts the count from zero.
- R10: `pumpLevel` follows {`curr1`,`curr2`} one cycle later, ordered by current: 00 gives 0 (about 5 µA), 01 gives 1 (200 µA), 11 gives 2 (300 µA) and 10 gives 3 (500 µA).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| bandAm | input | 1 | Band select, 1 = AM rates |
| stepWide | input | 1 | Step select, 1 = the wider step |
| curr1 | input | 1 | Pump current select, first bit |
| curr2 | input | 1 | Pump current select, second bit |
| standby | input | 1 | Low-power hold |
| fbPulse | input | 1 | Feedback pulse from the main divider, synchronous to clk |
| refPulse | output | 1 | One-cycle comparison tick |
| pumpUp | output | 1 | Source enable for the charge pump |
| pumpDn | output | 1 | Sink enable for the charge pump |
| pumpOff | output | 1 | High when the pump output is at high impedance |
| pumpLevel | output | 2 | Pump current level, 0 lowest to 3 highest |

## Verification
A wrong count value in the divider shows up as a tick that comes early or late, so the error is visible one period after the fault, at most 4000 cycles later. A stuck or unpaired detector latch shows up as an enable whose width no longer equals the lag, or as an enable that never clears. The bench sweeps the lag in both directions, so such a fault appears within one comparison period. Faults in the hold and restart paths show up as an offset in the next tick and as enables that survive the event.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic       restart;   // ratio changed: zero the count, clear detector
    logic       hold;      // standby: freeze count, silence detector
    logic [1:0] ratioSel;  // {band, step}
  } divCtl_t;

  // Pump current level, ordered by magnitude
  typedef enum logic [1:0] {
    LVL_MIN  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_MAX  = 2'd3
  } pumpLvl_e;

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pfd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bandAm,
  input  logic    stepWide,
  input  logic    standby,
  output divCtl_t ctl
);

  logic [1:0] selNow;
  logic [1:0] selReg;

  assign selNow = {bandAm, stepWide};

  always_ff @(posedge clk) begin
    if (!rstN) selReg <= 2'b00;
    else       selReg <= selNow;
  end

  always_comb begin
    ctl.restart  = (selNow != selReg);
    ctl.hold     = standby;
    ctl.ratioSel = selNow;
  end

endmodule

// File: rtl/refdiv_pfd_core.sv
module refdiv_pfd_core (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic refTick,
  input  logic fbIn,
  output logic up,
  output logic dn
);

  logic fbPrev;
  logic fbRise;
  logic bothSet;

  assign fbRise  = fbIn & ~fbPrev;
  assign bothSet = up & dn;

  always_ff @(posedge clk) begin
    if (!rstN) fbPrev <= 1'b0;
    else       fbPrev <= fbIn;
  end

  // Clearing wins over new edges in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN || clr || bothSet) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | refTick;
      dn <= dn | fbRise;
    end
  end

endmodule

// File: rtl/refdiv_dp.sv
module refdiv_dp
  import refdiv_pfd_pkg::*;
#(
  parameter int DIV_FM_FINE   = 320,
  parameter int DIV_FM_COARSE = 160,
  parameter int DIV_AM_FINE   = 4000,
  parameter int DIV_AM_COARSE = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  divCtl_t    ctl,
  input  logic       fbPulse,
  input  logic       curr1,
  input  logic       curr2,
  output logic       refPulse,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic [1:0] pumpLevel
);

  localparam int MAX_FM  = (DIV_FM_FINE > DIV_FM_COARSE) ? DIV_FM_FINE : DIV_FM_COARSE;
  localparam int MAX_AM  = (DIV_AM_FINE > DIV_AM_COARSE) ? DIV_AM_FINE : DIV_AM_COARSE;
  localparam int MAX_DIV = (MAX_FM > MAX_AM) ? MAX_FM : MAX_AM;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termCnt;
  logic             refQ;
  pumpLvl_e         lvlQ;
  pumpLvl_e         lvlNext;

  always_comb begin
    unique case (ctl.ratioSel)
      2'b00:   termCnt = CNT_W'(DIV_FM_FINE - 1);
      2'b01:   termCnt = CNT_W'(DIV_FM_COARSE - 1);
      2'b10:   termCnt = CNT_W'(DIV_AM_FINE - 1);
      default: termCnt = CNT_W'(DIV_AM_COARSE - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      refQ <= 1'b0;
    end else if (ctl.restart) begin
      cnt  <= '0;
      refQ <= 1'b0;
    end else if (ctl.hold) begin
      refQ <= 1'b0;
    end else if (cnt == termCnt) begin
      cnt  <= '0;
      refQ <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      refQ <= 1'b0;
    end
  end

  assign refPulse = refQ;

  refdiv_pfd_core u_pfd (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (ctl.restart | ctl.hold),
    .refTick (refQ),
    .fbIn    (fbPulse),
    .up      (pumpUp),
    .dn      (pumpDn)
  );

  always_comb begin
    unique case ({curr1, curr2})
      2'b00:   lvlNext = LVL_MIN;
      2'b01:   lvlNext = LVL_LOW;
      2'b11:   lvlNext = LVL_MID;
      default: lvlNext = LVL_MAX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) lvlQ <= LVL_MIN;
    else       lvlQ <= lvlNext;
  end

  assign pumpLevel = lvlQ;

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd
  import refdiv_pfd_pkg::*;
#(
  parameter int DIV_FM_FINE   = 320,
  parameter int DIV_FM_COARSE = 160,
  parameter int DIV_AM_FINE   = 4000,
  parameter int DIV_AM_COARSE = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bandAm,
  input  logic       stepWide,
  input  logic       curr1,
  input  logic       curr2,
  input  logic       standby,
  input  logic       fbPulse,
  output logic       refPulse,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpOff,
  output logic [1:0] pumpLevel
);

  divCtl_t ctl;

  refdiv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bandAm   (bandAm),
    .stepWide (stepWide),
    .standby  (standby),
    .ctl      (ctl)
  );

  refdiv_dp #(
    .DIV_FM_FINE   (DIV_FM_FINE),
    .DIV_FM_COARSE (DIV_FM_COARSE),
    .DIV_AM_FINE   (DIV_AM_FINE),
    .DIV_AM_COARSE (DIV_AM_COARSE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .fbPulse   (fbPulse),
    .curr1     (curr1),
    .curr2     (curr2),
    .refPulse  (refPulse),
    .pumpUp    (pumpUp),
    .pumpDn    (pumpDn),
    .pumpLevel (pumpLevel)
  );

  assign pumpOff = ~(pumpUp | pumpDn);

endmodule

// File: rtl/refdiv_pfd_chk.sv
module refdiv_pfd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bandAm,
  input logic       stepWide,
  input logic       curr1,
  input logic       curr2,
  input logic       standby,
  input logic       refPulse,
  input logic       pumpUp,
  input logic       pumpDn,
  input logic [1:0] pumpLevel
);

  // R3
  ref_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse);

  // R4
  up_follows_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPulse && !standby && ({bandAm, stepWide} == $past({bandAm, stepWide})))
      |=> pumpUp);

  // R6
  both_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pumpUp && pumpDn) |=> (!pumpUp && !pumpDn));

  // R8
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!refPulse && !pumpUp && !pumpDn));

  // R9
  ratio_change_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({bandAm, stepWide} != $past({bandAm, stepWide}))
      |=> (!refPulse && !pumpUp && !pumpDn));

  // R10
  level_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curr1 && !curr2) |=> (pumpLevel == 2'd3));

  // R10
  level_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curr1 && curr2) |=> (pumpLevel == 2'd2));

endmodule

bind refdiv_pfd refdiv_pfd_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bandAm    (bandAm),
  .stepWide  (stepWide),
  .curr1     (curr1),
  .curr2     (curr2),
  .standby   (standby),
  .refPulse  (refPulse),
  .pumpUp    (pumpUp),
  .pumpDn    (pumpDn),
  .pumpLevel (pumpLevel)
);

// File: tb/sim_refdiv_pfd.sv
module sim_refdiv_pfd;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bandAm = 1'b0;
  logic       stepWide = 1'b0;
  logic       curr1 = 1'b0;
  logic       curr2 = 1'b0;
  logic       standby = 1'b0;
  logic       fbPulse = 1'b0;
  logic       refPulse;
  logic       pumpUp;
  logic       pumpDn;
  logic       pumpOff;
  logic [1:0] pumpLevel;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;   // 100 MHz

  refdiv_pfd u0 (
    .clk(clk), .rstN(rstN), .bandAm(bandAm), .stepWide(stepWide),
    .curr1(curr1), .curr2(curr2), .standby(standby), .fbPulse(fbPulse),
    .refPulse(refPulse), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpOff(pumpOff), .pumpLevel(pumpLevel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int periodOf(input logic [1:0] s);
    case (s)
      2'b00:   return 320;
      2'b01:   return 160;
      2'b10:   return 4000;
      default: return 1600;
    endcase
  endfunction

  function automatic int levelOf(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic waitRef();
    bit seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (refPulse) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, "R2 tick arrives", int'(seen), 1);
  endtask

  // R2 R4 R9: restart with a pending up enable, then measure two periods
  task automatic measurePeriod(input logic [1:0] s);
    int n = periodOf(s);
    waitRef();
    @(negedge clk);
    chk(pumpUp == 1'b1, "R4 up after tick", int'(pumpUp), 1);
    bandAm = s[1];
    stepWide = s[0];
    @(negedge clk);
    chk(!pumpUp && !pumpDn, "R9 restart clears detector", int'({pumpUp, pumpDn}), 0);
    for (int k = 2; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == n)     chk(refPulse == 1'b0, "R2 no early tick", int'(refPulse), 0);
      if (k == n + 1) chk(refPulse == 1'b1, "R2 first period", int'(refPulse), 1);
    end
    repeat (n) @(negedge clk);
    chk(refPulse == 1'b1, "R2 steady period", int'(refPulse), 1);
  endtask

  // R5 R6 R7: reference leads by lag cycles, feedback held high three cycles
  task automatic lagSweep(input int lag);
    int upOnly = 0, dnOnly = 0, both = 0;
    bit offOk = 1'b1;
    waitRef();
    if (lag == 0) fbPulse = 1'b1;
    for (int i = 1; i <= lag + 6; i++) begin
      @(negedge clk);
      if (pumpUp && !pumpDn) upOnly++;
      if (!pumpUp && pumpDn) dnOnly++;
      if (pumpUp && pumpDn)  both++;
      if (pumpOff != !(pumpUp || pumpDn)) offOk = 1'b0;
      if (i == lag)     fbPulse = 1'b1;
      if (i == lag + 3) fbPulse = 1'b0;
    end
    chk(upOnly == lag, "R6 up width equals lag", upOnly, lag);
    chk(both == 1, "R6 overlap one cycle", both, 1);
    chk(dnOnly == 0, "R5 held feedback single edge", dnOnly, 0);
    chk(offOk, "R7 off flag", int'(offOk), 1);
  endtask

  // R5 R6: feedback leads the next tick by period-j2 cycles
  task automatic leadSweep(input int j2);
    int n = 160;
    int upOnly = 0, dnOnly = 0, both = 0;
    waitRef();
    fbPulse = 1'b1;
    for (int i = 1; i <= n + 3; i++) begin
      @(negedge clk);
      if (pumpUp && !pumpDn) upOnly++;
      if (!pumpUp && pumpDn) dnOnly++;
      if (pumpUp && pumpDn)  both++;
      if (i == 1)      fbPulse = 1'b0;
      if (i == j2)     fbPulse = 1'b1;
      if (i == j2 + 1) fbPulse = 1'b0;
    end
    chk(dnOnly == n - j2, "R5 down width equals lead", dnOnly, n - j2);
    chk(upOnly == 0, "R6 no stray up", upOnly, 0);
    chk(both == 2, "R6 two overlaps", both, 2);
  endtask

  // R8: standby for k cycles delays the tick by k and mutes the detector
  task automatic standbyTest(input int k);
    int n = 160;
    bit quiet = 1'b1;
    waitRef();
    standby = 1'b1;
    for (int i = 1; i <= k + n; i++) begin
      @(negedge clk);
      if (i <= k && (refPulse || pumpUp || pumpDn || !pumpOff)) quiet = 1'b0;
      if (i == 10) fbPulse = 1'b1;
      if (i == 11) fbPulse = 1'b0;
      if (i == k) standby = 1'b0;
      if (i == k + 5) chk(!pumpUp && !pumpDn, "R8 feedback ignored", int'({pumpUp, pumpDn}), 0);
      if (i == k + n - 1) chk(refPulse == 1'b0, "R8 count held", int'(refPulse), 0);
      if (i == k + n)     chk(refPulse == 1'b1, "R8 count resumes", int'(refPulse), 1);
    end
    chk(quiet, "R8 outputs quiet", int'(quiet), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(refPulse == 1'b0, "R1 ref", int'(refPulse), 0);
    chk(!pumpUp && !pumpDn, "R1 enables", int'({pumpUp, pumpDn}), 0);
    chk(pumpOff == 1'b1, "R1 off", int'(pumpOff), 1);
    chk(pumpLevel == 2'd0, "R1 level", int'(pumpLevel), 0);
    rstN = 1'b1;
    for (int k = 1; k <= 321; k++) begin
      @(negedge clk);
      if (k == 319) chk(refPulse == 1'b0, "R2 reset period early", int'(refPulse), 0);
      if (k == 320) chk(refPulse == 1'b1, "R2 reset period", int'(refPulse), 1);
      if (k == 321) begin
        chk(refPulse == 1'b0, "R3 single cycle", int'(refPulse), 0);
        chk(pumpUp == 1'b1, "R4 up after tick", int'(pumpUp), 1);
      end
    end
    measurePeriod(2'b01);
    measurePeriod(2'b11);
    measurePeriod(2'b10);
    measurePeriod(2'b00);
    measurePeriod(2'b01);
    for (int l = 0; l <= 6; l++) lagSweep(l);
    leadSweep(159);
    leadSweep(155);
    leadSweep(120);
    standbyTest(50);
    standbyTest(3);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      {curr1, curr2} = 2'(c);
      @(negedge clk);
      chk(int'(pumpLevel) == levelOf(2'(c)), "R10 level map", int'(pumpLevel), levelOf(2'(c)));
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) chk(1'b0, "watchdog", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule